// File: doc/BRIEF.md
# Timestamped Input Event Recorder with Cycle-Exact Replay

This block sits on the boundary between an I/O clock domain's inbound traffic and the logic that consumes it. Each cycle it may receive a 16-bit data word, an interrupt code, or both. In record mode it forwards them unchanged and also stores them in an on-chip log, each tagged with the value of a free-running domain-clock counter. That counter is cleared at every checkpoint. To save storage, an entry holds only the distance in cycles from the previously stored entry. When the input stays quiet for longer than that delta field can express, the block inserts a time-marker entry that carries the full 32-bit count.

In replay mode the live inputs are cut off and traffic toward the I/O side is suppressed. The block rewinds to the first stored entry, rebuilds each absolute timestamp from the deltas and markers, and drives every logged event on the exact cycle whose counter value matches the one seen during recording. Normal mode forwards the inputs and stores nothing. A near-full flag asks the surrounding system to take a fresh checkpoint before the log runs out.

Top module: `evlog_top`

## Requirements
- R1: In normal mode (mode 2'b00) the outputs equal the live inputs in the same cycle, the outbound path passes through, and nothing is stored.
- R2: In record mode (mode 2'b01) the outputs still equal the live inputs in the same cycle, and every cycle with a data or interrupt event is stored with its counter value.
- R3: In replay mode (mode 2'b10), after a switch cycle that also asserts the counter clear, each stored event appears at the outputs in the cycle whose counter value equals the one at which it was recorded, with the same data, interrupt code and valid flags. No output appears in any other cycle.
- R4: While in replay mode, the live inputs have no effect on the outputs, and the outbound valid is held low with its data forced to zero.
- R5: An idle stretch longer than 2^DELTA_W-1 cycles (255 by default) between two events is still replayed with exact timing.
- R6: near_full is high exactly while the number of stored entries is at least DEPTH-SLACK (60 by default). Once DEPTH entries are stored, further events are not kept.
- R7: The counter clear makes the counter read 0 in the following cycle. In record mode it also empties the log, and an event presented in that same cycle is not stored.
- R8: Each entry into replay mode rewinds to the first entry, so a second replay reproduces the same sequence.
- R9: The mode code 2'b11 behaves as normal mode: inputs pass through and nothing is stored.
- R10: After reset the outputs and near_full are low and the log is empty.
- R11: A data word and an interrupt code arriving in the same cycle are stored as one event and replayed together in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | 00 normal, 01 record, 10 replay, 11 normal |
| cnt_clr | input | 1 | Checkpoint counter clear |
| live_dv | input | 1 | Live data word valid |
| live_data | input | 16 | Live data word |
| live_iv | input | 1 | Live interrupt valid |
| live_irq | input | 8 | Live interrupt code |
| out_dv | output | 1 | Delivered data valid |
| out_data | output | 16 | Delivered data word |
| out_iv | output | 1 | Delivered interrupt valid |
| out_irq | output | 8 | Delivered interrupt code |
| tx_dv_in | input | 1 | Outbound data valid from the core side |
| tx_data_in | input | 16 | Outbound data from the core side |
| tx_dv_out | output | 1 | Outbound data valid toward the I/O side |
| tx_data_out | output | 16 | Outbound data toward the I/O side |
| near_full | output | 1 | Log nearly full, checkpoint requested |

## Verification
Errors in the delta reference, the marker insertion or the read pointer all surface the same way: a replayed event shows up one or more cycles early or late, or not at all. Every replay cycle is compared against the recording, so a slip shows up at the very first event whose reconstructed time is wrong. A long idle gap exercises the markers, and a write counter that runs off by one flips near_full at the wrong entry. A fill bound that fails to stop writing shows up as extra events after entry 64 on replay.

// File: rtl/evlog_pkg.sv
package evlog_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_RECORD = 2'b01,
        MODE_REPLAY = 2'b10,
        MODE_SPARE  = 2'b11
    } mode_e;
endpackage

// File: rtl/evlog_clock_count.sv
module evlog_clock_count #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    output logic [TS_W-1:0] cnt
);
    typedef struct packed {
        logic [TS_W-1:0] cnt;
    } cc_state_t;

    cc_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) s_d.cnt = '0;
        else     s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt = s_q.cnt;
endmodule

// File: rtl/evlog_writer.sv
module evlog_writer #(
    parameter int DATA_W  = 16,
    parameter int IRQ_W   = 8,
    parameter int DELTA_W = 8,
    parameter int TS_W    = 32,
    parameter int DEPTH   = 64,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int FILL_W = ADDR_W + 1,
    localparam int BODY_W = IRQ_W + DATA_W + DELTA_W,
    localparam int ENT_W  = BODY_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec_en,
    input  logic              clr,
    input  logic [TS_W-1:0]   cnt,
    input  logic              ev_dv,
    input  logic [DATA_W-1:0] ev_data,
    input  logic              ev_iv,
    input  logic [IRQ_W-1:0]  ev_irq,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ENT_W-1:0]  wr_entry,
    output logic [FILL_W-1:0] fill
);
    localparam logic [TS_W-1:0]   GAP_LIM = {{(TS_W-DELTA_W){1'b0}}, {DELTA_W{1'b1}}};
    localparam logic [FILL_W-1:0] CAP     = FILL_W'(DEPTH);

    typedef struct packed {
        logic [FILL_W-1:0] wr_ptr;
        logic [TS_W-1:0]   last_ts;
    } wr_state_t;

    wr_state_t       s_d, s_q;
    logic [TS_W-1:0] gap;
    logic            take;
    logic            room;

    assign gap  = cnt - s_q.last_ts;
    assign room = (s_q.wr_ptr < CAP);

    always_comb begin
        s_d      = s_q;
        wr_en    = 1'b0;
        take     = 1'b0;
        wr_entry = '0;
        wr_addr  = s_q.wr_ptr[ADDR_W-1:0];
        if (clr) begin
            s_d.last_ts = '0;
            if (rec_en) s_d.wr_ptr = '0;
        end else if (rec_en) begin
            if (ev_dv || ev_iv) begin
                wr_entry = {1'b0, ev_iv, ev_dv, ev_irq, ev_data, gap[DELTA_W-1:0]};
                take     = 1'b1;
            end else if (gap >= GAP_LIM) begin
                wr_entry[ENT_W-1]  = 1'b1;
                wr_entry[TS_W-1:0] = cnt;
                take               = 1'b1;
            end
            if (take) begin
                s_d.last_ts = cnt;
                if (room) begin
                    wr_en      = 1'b1;
                    s_d.wr_ptr = s_q.wr_ptr + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fill = s_q.wr_ptr;
endmodule

// File: rtl/evlog_store.sv
module evlog_store #(
    parameter int ENT_W = 35,
    parameter int DEPTH = 64,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [ENT_W-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [ENT_W-1:0]  rdata
);
    logic [ENT_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/evlog_player.sv
module evlog_player #(
    parameter int DATA_W  = 16,
    parameter int IRQ_W   = 8,
    parameter int DELTA_W = 8,
    parameter int TS_W    = 32,
    parameter int DEPTH   = 64,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int FILL_W = ADDR_W + 1,
    localparam int BODY_W = IRQ_W + DATA_W + DELTA_W,
    localparam int ENT_W  = BODY_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              play_en,
    input  logic [TS_W-1:0]   cnt,
    input  logic [FILL_W-1:0] fill,
    input  logic [ENT_W-1:0]  rd_entry,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [FILL_W-1:0] play_ptr,
    output logic              p_dv,
    output logic [DATA_W-1:0] p_data,
    output logic              p_iv,
    output logic [IRQ_W-1:0]  p_irq
);
    typedef struct packed {
        logic              active;
        logic [FILL_W-1:0] rd_ptr;
        logic [TS_W-1:0]   ref_ts;
    } pl_state_t;

    pl_state_t          s_d, s_q;
    logic               is_mark;
    logic [BODY_W-1:0]  body;
    logic [DELTA_W-1:0] delta;
    logic [TS_W-1:0]    target;

    assign is_mark = rd_entry[ENT_W-1];
    assign body    = rd_entry[BODY_W-1:0];
    assign delta   = body[DELTA_W-1:0];
    assign target  = is_mark ? body[TS_W-1:0]
                             : s_q.ref_ts + {{(TS_W-DELTA_W){1'b0}}, delta};

    always_comb begin
        s_d        = s_q;
        s_d.active = play_en;
        p_dv       = 1'b0;
        p_iv       = 1'b0;
        p_data     = '0;
        p_irq      = '0;
        if (play_en && !s_q.active) begin
            s_d.rd_ptr = '0;
            s_d.ref_ts = '0;
        end else if (play_en && (s_q.rd_ptr < fill) && (target == cnt)) begin
            s_d.rd_ptr = s_q.rd_ptr + 1'b1;
            s_d.ref_ts = target;
            if (!is_mark) begin
                p_dv   = rd_entry[ENT_W-3];
                p_iv   = rd_entry[ENT_W-2];
                p_data = body[DELTA_W +: DATA_W];
                p_irq  = body[DELTA_W+DATA_W +: IRQ_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_addr  = s_q.rd_ptr[ADDR_W-1:0];
    assign play_ptr = s_q.rd_ptr;
endmodule

// File: rtl/evlog_top.sv
module evlog_top #(
    parameter int DATA_W  = 16,
    parameter int IRQ_W   = 8,
    parameter int DELTA_W = 8,
    parameter int TS_W    = 32,
    parameter int DEPTH   = 64,
    parameter int SLACK   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              cnt_clr,
    input  logic              live_dv,
    input  logic [DATA_W-1:0] live_data,
    input  logic              live_iv,
    input  logic [IRQ_W-1:0]  live_irq,
    output logic              out_dv,
    output logic [DATA_W-1:0] out_data,
    output logic              out_iv,
    output logic [IRQ_W-1:0]  out_irq,
    input  logic              tx_dv_in,
    input  logic [DATA_W-1:0] tx_data_in,
    output logic              tx_dv_out,
    output logic [DATA_W-1:0] tx_data_out,
    output logic              near_full
);
    import evlog_pkg::*;

    localparam int ADDR_W = $clog2(DEPTH);
    localparam int FILL_W = ADDR_W + 1;
    localparam int ENT_W  = IRQ_W + DATA_W + DELTA_W + 3;
    localparam logic [FILL_W-1:0] NF_MARK = FILL_W'(DEPTH - SLACK);

    mode_e             cur_mode;
    logic              rec_en, play_en;
    logic [TS_W-1:0]   dom_cnt;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [ENT_W-1:0]  wr_entry, rd_entry;
    logic [FILL_W-1:0] wr_fill, rd_ptr;
    logic              p_dv, p_iv;
    logic [DATA_W-1:0] p_data;
    logic [IRQ_W-1:0]  p_irq;

    assign cur_mode = mode_e'(mode);
    assign rec_en   = (cur_mode == MODE_RECORD);
    assign play_en  = (cur_mode == MODE_REPLAY);

    evlog_clock_count #(.TS_W(TS_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .cnt(dom_cnt)
    );

    evlog_writer #(
        .DATA_W(DATA_W), .IRQ_W(IRQ_W), .DELTA_W(DELTA_W), .TS_W(TS_W), .DEPTH(DEPTH)
    ) wr_i (
        .clk(clk), .rst_n(rst_n), .rec_en(rec_en), .clr(cnt_clr), .cnt(dom_cnt),
        .ev_dv(live_dv), .ev_data(live_data), .ev_iv(live_iv), .ev_irq(live_irq),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_entry(wr_entry), .fill(wr_fill)
    );

    evlog_store #(.ENT_W(ENT_W), .DEPTH(DEPTH)) mem_i (
        .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_entry),
        .raddr(rd_addr), .rdata(rd_entry)
    );

    evlog_player #(
        .DATA_W(DATA_W), .IRQ_W(IRQ_W), .DELTA_W(DELTA_W), .TS_W(TS_W), .DEPTH(DEPTH)
    ) pl_i (
        .clk(clk), .rst_n(rst_n), .play_en(play_en), .cnt(dom_cnt), .fill(wr_fill),
        .rd_entry(rd_entry), .rd_addr(rd_addr), .play_ptr(rd_ptr),
        .p_dv(p_dv), .p_data(p_data), .p_iv(p_iv), .p_irq(p_irq)
    );

    always_comb begin
        if (play_en) begin
            out_dv      = p_dv;
            out_data    = p_data;
            out_iv      = p_iv;
            out_irq     = p_irq;
            tx_dv_out   = 1'b0;
            tx_data_out = '0;
        end else begin
            out_dv      = live_dv;
            out_data    = live_data;
            out_iv      = live_iv;
            out_irq     = live_irq;
            tx_dv_out   = tx_dv_in;
            tx_data_out = tx_data_in;
        end
    end

    assign near_full = (wr_fill >= NF_MARK);
endmodule

// File: rtl/evlog_chk.sv
module evlog_chk #(
    parameter int DEPTH  = 64,
    parameter int TS_W   = 32,
    localparam int FILL_W = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic              cnt_clr,
    input logic              live_dv,
    input logic              live_iv,
    input logic              out_dv,
    input logic              out_iv,
    input logic              tx_dv_out,
    input logic              near_full,
    input logic [FILL_W-1:0] fill,
    input logic [FILL_W-1:0] play_ptr,
    input logic [TS_W-1:0]   cnt
);
    AST_NORMAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |-> (out_dv == live_dv && out_iv == live_iv)); // R1
    AST_NO_LOG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b01) |=> $stable(fill)); // R1
    AST_REPLAY_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && $past(mode) == 2'b10) |-> (play_ptr <= fill)); // R3
    AST_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |-> !tx_dv_out); // R4
    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FILL_W'(DEPTH)); // R6
    AST_NF_FROM_REC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(near_full) |-> ($past(mode) == 2'b01)); // R6
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (cnt == '0)); // R7
endmodule

bind evlog_top evlog_chk #(.DEPTH(DEPTH), .TS_W(TS_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cnt_clr(cnt_clr),
    .live_dv(live_dv), .live_iv(live_iv), .out_dv(out_dv), .out_iv(out_iv),
    .tx_dv_out(tx_dv_out), .near_full(near_full), .fill(wr_fill),
    .play_ptr(rd_ptr), .cnt(dom_cnt)
);

// File: tb/evlog_top_tb_top.sv
`timescale 1ns/1ps
module evlog_top_tb_top;
    localparam int DEPTH = 64;
    localparam int SLACK = 4;
    localparam int MAXC  = 1024;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  mode;
    logic        cnt_clr;
    logic        live_dv, live_iv, tx_dv_in;
    logic [15:0] live_data, tx_data_in;
    logic [7:0]  live_irq;
    logic        out_dv, out_iv, tx_dv_out, near_full;
    logic [15:0] out_data, tx_data_out;
    logic [7:0]  out_irq;

    always #2.5 clk = ~clk;

    evlog_top dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .cnt_clr(cnt_clr),
        .live_dv(live_dv), .live_data(live_data), .live_iv(live_iv), .live_irq(live_irq),
        .out_dv(out_dv), .out_data(out_data), .out_iv(out_iv), .out_irq(out_irq),
        .tx_dv_in(tx_dv_in), .tx_data_in(tx_data_in),
        .tx_dv_out(tx_dv_out), .tx_data_out(tx_data_out), .near_full(near_full)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit          e_dv [MAXC];
    bit          e_iv [MAXC];
    logic [15:0] e_data [MAXC];
    logic [7:0]  e_irq [MAXC];
    int          rec_len = 0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(logic [1:0] m, logic c, logic dv, logic [15:0] d, logic iv, logic [7:0] q);
        @(negedge clk);
        mode = m; cnt_clr = c;
        live_dv = dv; live_data = d; live_iv = iv; live_irq = q;
        tx_dv_in = 1'($urandom % 2); tx_data_in = 16'($urandom);
        #1;
    endtask

    task automatic drive_rand(logic [1:0] m, logic c);
        drive(m, c, 1'($urandom % 2), 16'($urandom), 1'($urandom % 2), 8'($urandom));
    endtask

    task automatic check_pass(string req);
        chk(out_dv == live_dv, req, "out_dv", out_dv, live_dv);
        chk(out_iv == live_iv, req, "out_iv", out_iv, live_iv);
        chk(out_data == live_data, req, "out_data", out_data, live_data);
        chk(out_irq == live_irq, req, "out_irq", out_irq, live_irq);
        chk(tx_dv_out == tx_dv_in && tx_data_out == tx_data_in, req, "tx pass", tx_data_out, tx_data_in);
    endtask

    function automatic bit want_dv(int c);
        return (c < rec_len) ? e_dv[c] : 1'b0;
    endfunction
    function automatic bit want_iv(int c);
        return (c < rec_len) ? e_iv[c] : 1'b0;
    endfunction

    task automatic clear_exp();
        for (int i = 0; i < MAXC; i++) begin
            e_dv[i] = 0; e_iv[i] = 0; e_data[i] = '0; e_irq[i] = '0;
        end
    endtask

    // Mixed random record: events near the start and the end, long quiet gap between.
    task automatic record_mixed(int len);
        int nev = 0;
        drive(2'b01, 1'b1, 1'b1, 16'hDEAD, 1'b1, 8'hEE); // R7: clear cycle event not stored
        check_pass("R2");
        clear_exp();
        rec_len = len;
        for (int c = 0; c < len; c++) begin
            bit ev = ((c < 100) || (c >= 700)) && ($urandom % 8 == 0) && (nev < 40);
            int kind = int'($urandom % 3);
            bit dv = 0, iv = 0;
            logic [15:0] d = 16'($urandom);
            logic [7:0]  q = 8'($urandom);
            if (c == 5) begin ev = 1; kind = 2; end
            if (ev) begin
                nev++;
                dv = (kind != 1); iv = (kind != 0);
                e_dv[c] = dv; e_iv[c] = iv; e_data[c] = d; e_irq[c] = q;
            end
            drive(2'b01, 1'b0, dv, d, iv, q);
            check_pass("R2");
            chk(near_full == 1'b0, "R6", "near_full low", near_full, 0);
        end
    endtask

    task automatic replay(int len, string req);
        drive_rand(2'b10, 1'b1);
        chk(out_dv == 0 && out_iv == 0, req, "switch cycle quiet", out_dv, 0);
        for (int c = 0; c < len; c++) begin
            string r = req;
            if (req == "R3" && c >= 700) r = "R5";
            if (req == "R3" && c == 5) r = "R11";
            drive_rand(2'b10, 1'b0); // R4: live inputs random, must not leak
            chk(out_dv == want_dv(c), r, $sformatf("dv at %0d", c), out_dv, want_dv(c));
            chk(out_iv == want_iv(c), r, $sformatf("iv at %0d", c), out_iv, want_iv(c));
            if (want_dv(c) && out_dv)
                chk(out_data == e_data[c], r, $sformatf("data at %0d", c), out_data, e_data[c]);
            if (want_iv(c) && out_iv)
                chk(out_irq == e_irq[c], r, $sformatf("irq at %0d", c), out_irq, e_irq[c]);
            chk(tx_dv_out == 0 && tx_data_out == 0, "R4", "tx suppressed", tx_data_out, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; mode = 2'b00; cnt_clr = 0;
        live_dv = 0; live_data = '0; live_iv = 0; live_irq = '0;
        tx_dv_in = 0; tx_data_in = '0;
        repeat (3) @(negedge clk);
        #1;
        chk(out_dv == 0 && out_iv == 0, "R10", "reset outputs", out_dv, 0);
        chk(near_full == 0, "R10", "reset near_full", near_full, 0);
        rst_n = 1;

        // R1: normal mode passes through and stores nothing
        for (int i = 0; i < 30; i++) begin
            drive_rand(2'b00, 1'b0);
            check_pass("R1");
        end
        clear_exp(); rec_len = 0;
        replay(40, "R1"); // empty log after reset and normal traffic (R10)

        // R2, R3, R5, R7, R11: mixed record then cycle-exact replay
        record_mixed(800);
        drive_rand(2'b00, 1'b0);
        replay(820, "R3");

        // R8: replay again without re-recording
        drive_rand(2'b00, 1'b0);
        replay(820, "R8");

        // R6: dense record beyond capacity
        drive(2'b01, 1'b1, 1'b0, 16'h0, 1'b0, 8'h0);
        clear_exp();
        rec_len = 70;
        for (int c = 0; c < 70; c++) begin
            if (c < DEPTH) begin
                e_dv[c] = 1; e_data[c] = 16'(c);
            end
            drive(2'b01, 1'b0, 1'b1, 16'(c), 1'b0, 8'h0);
            chk(near_full == (c >= DEPTH - SLACK), "R6", $sformatf("near_full at %0d", c),
                near_full, (c >= DEPTH - SLACK));
        end
        drive(2'b01, 1'b0, 1'b0, 16'h0, 1'b0, 8'h0);
        chk(near_full == 1, "R6", "near_full held", near_full, 1);
        replay(80, "R6");

        // R9: spare mode code behaves as normal and stores nothing
        for (int i = 0; i < 20; i++) begin
            drive_rand(2'b11, 1'b0);
            check_pass("R9");
        end
        replay(80, "R9");

        drive_rand(2'b00, 1'b0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule